// File: doc/BRIEF.md
# Radix-8 Signed-Digit Word Adder

This block adds two words of radix-8 signed digits with no carry chain across the word. Every digit is a 4-bit code holding a value between -7 and +7. One extra code marks a position that holds no significant digit. Each digit slice works in two local steps. The first step adds the two operand digits and splits the result into an interim digit and a transfer of -1, 0 or +1 for the next more significant slice. The second step adds to the interim digit the transfer that arrives from the less significant slice. The delay is that of one slice, whatever the word length.

A subtract control negates every digit of the second operand before the addition. A mode select chooses conventional or significance handling of the non-significant code. A 2-bit transfer input enters at the least significant slice. The word result is the sum digits plus an overflow flag, which is raised when the most significant slice sends out a nonzero transfer. The adder is purely combinational and holds no state.

Top module: `sd_radix8_adder`

## Requirements
- R1: A digit code is read as a 4-bit two's-complement value: 0000..0111 are 0..+7 and 1111..1001 are -1..-7. Code 1000 is the non-significant (space) code. Digit i occupies bits [4i+3:4i], and digit 0 is the least significant. The word value is the sum over i of digit_i times 8^i.
- R2: Step one forms p = a + b for each slice. If p > 6 the slice sends a transfer of +1 and keeps p - 8. If p < -6 it sends -1 and keeps p + 8. Otherwise it sends 0 and keeps p.
- R3: The interim digit that a slice keeps always lies in -6..+6.
- R4: Each non-space output digit equals the interim digit plus the incoming transfer, and it always lies in -7..+7.
- R5: A space input digit takes part in the addition as the value zero. It still sends its normal transfer, and two space inputs send no transfer.
- R6: When significance mode is selected (mode input 1), an output digit is 1000 whenever either input digit at that position is 1000.
- R7: When conventional mode is selected (mode input 0), an output digit is 1000 only when both input digits at that position are 1000.
- R8: With subtract set, every second-operand digit is replaced by its 4-bit two's complement before the addition, except that a space digit stays the space code.
- R9: The overflow flag is 1 exactly when the transfer out of the most significant digit is nonzero.
- R10: The transfer input adds its value at digit 0, with 00 = 0, 01 = +1 and 11 = -1. The code 10 has no effect and acts as 0.
- R11: For operands without space digits, the value of the result plus the outgoing transfer times 8^N equals the integer sum (or difference) of the operands plus the transfer input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_digits_i | input | 4*N_DIGITS | First operand, digit 0 in the low nibble |
| b_digits_i | input | 4*N_DIGITS | Second operand, negated when subtracting |
| sub_i | input | 1 | 1 selects a - b, 0 selects a + b |
| sig_mode_i | input | 1 | 1 selects significance handling of space digits, 0 conventional |
| xfer_in_i | input | 2 | Transfer entering digit 0 (00=0, 01=+1, 11=-1, 10 ignored) |
| sum_digits_o | output | 4*N_DIGITS | Result digits |
| ovf_o | output | 1 | Nonzero transfer left the most significant digit |

## Verification
The hardest case to reach is the one where a slice both changes its interim value and receives a transfer that pushes the digit toward the edge of its range. Another is the case where the transfer from every slice is nonzero at the same time, so that all transfers must land in a single pass. Directed words of all +7 or all -7 digits force a transfer out of every slice at once. Single-digit vectors sit just on either side of the +/-6 split to pin down the transfer rule. Space-code cases are placed next to a digit that sends a transfer, so that the forcing rule and the value-zero rule are seen together. Random legal words in both directions then cover the value relation.

// File: rtl/sdadd_pkg.sv
package sdadd_pkg;
   // Mode select encoding for the space-code forcing rule
   typedef enum logic {
      MODE_CONV = 1'b0,
      MODE_SIG  = 1'b1
   } sd_mode_e;

   // Transfer digit: two's complement, legal values -1, 0, +1
   typedef logic signed [1:0] sd_xfer_t;

   localparam sd_xfer_t XFER_ZERO = 2'sb00;
   localparam sd_xfer_t XFER_POS  = 2'sb01;
   localparam sd_xfer_t XFER_NEG  = 2'sb11;
   localparam sd_xfer_t XFER_BAD  = 2'sb10;
endpackage

// File: rtl/sd_digit_in.sv
module sd_digit_in #(
   parameter int K = 3,
   localparam int DW = K + 1
) (
   input  logic [DW-1:0]       a_code,
   input  logic [DW-1:0]       b_code,
   input  logic                sub,
   output logic signed [K:0]   a_val,
   output logic signed [K:0]   b_val,
   output logic                a_sp,
   output logic                b_sp
);
   localparam logic [DW-1:0] SPACE = {1'b1, {K{1'b0}}};
   localparam logic [DW-1:0] ONE   = {{K{1'b0}}, 1'b1};

   logic [DW-1:0] b_eff;

   always_comb begin
      a_sp  = (a_code == SPACE);
      b_sp  = (b_code == SPACE);
      // negate the subtrahend digit, leaving the space code untouched
      b_eff = (sub && !b_sp) ? ((~b_code) + ONE) : b_code;
      // the space code contributes a zero value
      a_val = a_sp ? '0 : $signed(a_code);
      b_val = b_sp ? '0 : $signed(b_eff);
   end
endmodule

// File: rtl/sd_xfer_stage.sv
module sd_xfer_stage
   import sdadd_pkg::*;
#(
   parameter int K = 3
) (
   input  logic signed [K:0] a_val,
   input  logic signed [K:0] b_val,
   output sd_xfer_t          t_out,
   output logic signed [K:0] w
);
   localparam int THR = (1 << K) - 2;
   localparam logic signed [K+1:0] THR_P = (K+2)'(THR);
   localparam logic signed [K+1:0] RAD_P = (K+2)'(1 << K);
   localparam logic signed [K:0]   THR_W = (K+1)'(THR);

   logic signed [K+1:0] pair;
   logic signed [K+1:0] wf;

   always_comb begin
      pair = (K+2)'(a_val) + (K+2)'(b_val);
      if (pair > THR_P) begin
         t_out = XFER_POS;
         wf    = pair - RAD_P;
      end else if (pair < -THR_P) begin
         t_out = XFER_NEG;
         wf    = pair + RAD_P;
      end else begin
         t_out = XFER_ZERO;
         wf    = pair;
      end
      w = $signed(wf[K:0]);
   end

   always_comb begin
      AST_INTERIM_RANGE: assert (w <= THR_W && w >= -THR_W); // R3
   end
endmodule

// File: rtl/sd_sum_stage.sv
module sd_sum_stage
   import sdadd_pkg::*;
#(
   parameter int K = 3,
   localparam int DW = K + 1
) (
   input  logic signed [K:0] w,
   input  sd_xfer_t          t_in,
   input  logic              a_sp,
   input  logic              b_sp,
   input  logic              sig_mode,
   output logic [DW-1:0]     code
);
   localparam logic [DW-1:0] SPACE = {1'b1, {K{1'b0}}};

   logic signed [K+1:0] s;
   logic                force_sp;

   always_comb begin
      s        = (K+2)'(w) + (K+2)'(t_in);
      force_sp = (sd_mode_e'(sig_mode) == MODE_SIG) ? (a_sp | b_sp) : (a_sp & b_sp);
      code     = force_sp ? SPACE : s[K:0];
   end

   always_comb begin
      if (!force_sp) begin
         AST_NO_STRAY_SPACE: assert (code != SPACE); // R7
      end
   end
endmodule

// File: rtl/sd_radix8_adder.sv
module sd_radix8_adder
   import sdadd_pkg::*;
#(
   parameter int N_DIGITS   = 8,
   parameter int RADIX_LOG2 = 3,
   localparam int DW = RADIX_LOG2 + 1,
   localparam int WW = N_DIGITS * DW
) (
   input  logic [WW-1:0] a_digits_i,
   input  logic [WW-1:0] b_digits_i,
   input  logic          sub_i,
   input  logic          sig_mode_i,
   input  logic [1:0]    xfer_in_i,
   output logic [WW-1:0] sum_digits_o,
   output logic          ovf_o
);
   localparam int K = RADIX_LOG2;

   if (N_DIGITS < 1) begin : g_bad_n
      $error("N_DIGITS must be at least 1");
   end
   if (RADIX_LOG2 < 2) begin : g_bad_radix
      $error("RADIX_LOG2 must be at least 2");
   end

   sd_xfer_t      xfer [N_DIGITS+1];
   logic [N_DIGITS-1:0] a_sp;
   logic [N_DIGITS-1:0] b_sp;

   // an undefined transfer code enters as zero
   assign xfer[0] = (sd_xfer_t'(xfer_in_i) == XFER_BAD) ? XFER_ZERO : sd_xfer_t'(xfer_in_i);

   for (genvar gi = 0; gi < N_DIGITS; gi++) begin : g_slice
      logic signed [K:0] a_val;
      logic signed [K:0] b_val;
      logic signed [K:0] w;

      sd_digit_in #(.K(K)) u_in (
         .a_code (a_digits_i[gi*DW +: DW]),
         .b_code (b_digits_i[gi*DW +: DW]),
         .sub    (sub_i),
         .a_val  (a_val),
         .b_val  (b_val),
         .a_sp   (a_sp[gi]),
         .b_sp   (b_sp[gi])
      );

      sd_xfer_stage #(.K(K)) u_step1 (
         .a_val (a_val),
         .b_val (b_val),
         .t_out (xfer[gi+1]),
         .w     (w)
      );

      sd_sum_stage #(.K(K)) u_step2 (
         .w        (w),
         .t_in     (xfer[gi]),
         .a_sp     (a_sp[gi]),
         .b_sp     (b_sp[gi]),
         .sig_mode (sig_mode_i),
         .code     (sum_digits_o[gi*DW +: DW])
      );
   end

   assign ovf_o = (xfer[N_DIGITS] != XFER_ZERO);

   always_comb begin
      for (int i = 0; i < N_DIGITS; i++) begin
         AST_XFER_LEGAL: assert (xfer[i+1] != XFER_BAD); // R2
         if (a_sp[i] && b_sp[i]) begin
            AST_SPACE_NO_XFER: assert (xfer[i+1] == XFER_ZERO); // R5
         end
      end
   end
endmodule

// File: tb/sd_radix8_adder_test.sv
module sd_radix8_adder_test;
   localparam int N  = 8;
   localparam int WW = 4 * N;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [WW-1:0] a_v = '0;
   logic [WW-1:0] b_v = '0;
   logic          sub = 1'b0;
   logic          sig = 1'b0;
   logic [1:0]    cin = 2'b00;
   logic [WW-1:0] sum_v;
   logic          ovf;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   sd_radix8_adder #(.N_DIGITS(N), .RADIX_LOG2(3)) uut (
      .a_digits_i   (a_v),
      .b_digits_i   (b_v),
      .sub_i        (sub),
      .sig_mode_i   (sig),
      .xfer_in_i    (cin),
      .sum_digits_o (sum_v),
      .ovf_o        (ovf)
   );

   function automatic int dec(input logic [3:0] c);
      return int'($signed(c));
   endfunction

   function automatic int word_val(input logic [WW-1:0] v);
      int acc = 0;
      for (int i = 0; i < N; i++) acc += dec(v[4*i +: 4]) * (1 << (3*i));
      return acc;
   endfunction

   task automatic apply(input logic [WW-1:0] a, input logic [WW-1:0] b,
                        input logic s, input logic m, input logic [1:0] c);
      @(posedge clk);
      a_v = a; b_v = b; sub = s; sig = m; cin = c;
      @(negedge clk);
   endtask

   task automatic expect_word(input string req, input logic [WW-1:0] exp_sum, input logic exp_ovf);
      checks++;
      if (sum_v !== exp_sum || ovf !== exp_ovf) begin
         errors++;
         $display("FAIL %s: sum=%h ovf=%b expected sum=%h ovf=%b", req, sum_v, ovf, exp_sum, exp_ovf);
      end
   endtask

   task automatic t_idle;
      apply('0, '0, 1'b0, 1'b0, 2'b00);
      expect_word("R1 zero operands", 32'h0000_0000, 1'b0);
   endtask

   task automatic t_transfer_rule;
      apply(32'h4, 32'h3, 1'b0, 1'b0, 2'b00);   // 7 -> keep -1, send +1
      expect_word("R2 p=+7", 32'h0000_001F, 1'b0);
      apply(32'h3, 32'h3, 1'b0, 1'b0, 2'b00);   // 6 stays
      expect_word("R2 p=+6", 32'h0000_0006, 1'b0);
      apply(32'hC, 32'hD, 1'b0, 1'b0, 2'b00);   // -7 -> keep +1, send -1
      expect_word("R2 p=-7", 32'h0000_00F1, 1'b0);
      apply(32'h7, 32'h7, 1'b0, 1'b0, 2'b00);   // 14 -> keep 6 (R3 bound)
      expect_word("R3 p=+14", 32'h0000_0016, 1'b0);
   endtask

   task automatic t_full_transfer;
      apply(32'h7777_7777, 32'h7777_7777, 1'b0, 1'b0, 2'b00);
      expect_word("R4 R9 all +7", 32'h7777_7776, 1'b1);
      apply(32'h9999_9999, 32'h9999_9999, 1'b0, 1'b0, 2'b00);
      expect_word("R4 R9 all -7", 32'h9999_999A, 1'b1);
   endtask

   task automatic t_xfer_in;
      apply('0, '0, 1'b0, 1'b0, 2'b01);
      expect_word("R10 cin +1", 32'h0000_0001, 1'b0);
      apply('0, '0, 1'b0, 1'b0, 2'b11);
      expect_word("R10 cin -1", 32'h0000_000F, 1'b0);
      apply(32'h7, '0, 1'b0, 1'b0, 2'b01);
      expect_word("R4 R10 7+cin", 32'h0000_0010, 1'b0);
      apply('0, '0, 1'b0, 1'b0, 2'b10);
      expect_word("R10 cin code 10 ignored", 32'h0000_0000, 1'b0);
   endtask

   task automatic t_space_sig;
      apply(32'h0000_0800, 32'h0000_0700, 1'b0, 1'b1, 2'b00);
      expect_word("R5 R6 one space sig", 32'h0000_1800, 1'b0);
      apply(32'h0000_0500, 32'h0000_0800, 1'b0, 1'b1, 2'b00);
      expect_word("R6 space on b sig", 32'h0000_0800, 1'b0);
   endtask

   task automatic t_space_conv;
      apply(32'h0000_0800, 32'h0000_0700, 1'b0, 1'b0, 2'b00);
      expect_word("R5 R7 one space conv", 32'h0000_1F00, 1'b0);
      apply(32'h0000_0800, 32'h0000_0800, 1'b0, 1'b0, 2'b00);
      expect_word("R5 R7 both space conv", 32'h0000_0800, 1'b0);
   endtask

   task automatic t_subtract;
      apply(32'h5, 32'h3, 1'b1, 1'b0, 2'b00);
      expect_word("R8 5-3", 32'h0000_0002, 1'b0);
      apply(32'h3, 32'h5, 1'b1, 1'b0, 2'b00);
      expect_word("R8 3-5", 32'h0000_000E, 1'b0);
      apply(32'h45, 32'h83, 1'b1, 1'b1, 2'b00);
      expect_word("R8 space subtrahend sig", 32'h0000_0082, 1'b0);
      apply(32'h45, 32'h80, 1'b1, 1'b0, 2'b00);
      expect_word("R8 space subtrahend conv", 32'h0000_0045, 1'b0);
   endtask

   task automatic t_random;
      for (int n = 0; n < 300; n++) begin
         logic [WW-1:0] ra, rb;
         logic          rs;
         logic [1:0]    rc;
         int            ci, expv, diff;
         bit            range_ok;
         for (int i = 0; i < N; i++) begin
            ra[4*i +: 4] = 4'(int'($urandom_range(14)) - 7);
            rb[4*i +: 4] = 4'(int'($urandom_range(14)) - 7);
         end
         rs = 1'($urandom_range(1));
         case ($urandom_range(2))
            0: rc = 2'b00;
            1: rc = 2'b01;
            default: rc = 2'b11;
         endcase
         ci = (rc == 2'b01) ? 1 : (rc == 2'b11) ? -1 : 0;
         apply(ra, rb, rs, 1'($urandom_range(1)), rc);
         expv = word_val(ra) + (rs ? -word_val(rb) : word_val(rb)) + ci;
         diff = expv - word_val(sum_v);
         checks++;
         if (!((diff == 0 && !ovf) || ((diff == (1 << 24) || diff == -(1 << 24)) && ovf))) begin
            errors++;
            $display("FAIL R11: value=%0d ovf=%b expected value=%0d", word_val(sum_v), ovf, expv);
         end
         range_ok = 1'b1;
         for (int i = 0; i < N; i++)
            if (sum_v[4*i +: 4] == 4'b1000) range_ok = 1'b0;
         checks++;
         if (!range_ok) begin
            errors++;
            $display("FAIL R4: sum=%h has a space digit, expected none", sum_v);
         end
      end
   endtask

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog: run incomplete, expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      t_idle();
      t_transfer_rule();
      t_full_transfer();
      t_xfer_in();
      t_space_sig();
      t_space_conv();
      t_subtract();
      t_random();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule